// File: doc/BRIEF.md
# Nibble-Serial Quadlet CRC-16 Engine

This block produces the 16-bit check value that guards map and ROM blocks carried on a serial bus. A client pulses `start` together with the number of 32-bit quadlets the check must cover, then hands the quadlets over one at a time through a valid/ready handshake. Each accepted quadlet is folded into the running check four bits per clock. The most significant nibble goes first. The fold is a shift-and-XOR form with feedback terms at bit positions 12, 5 and 0. After the last quadlet the block raises `done` for one cycle and holds the result until the next `start`.

A header option turns the result into a ready-made header quadlet. The covered length, in quadlets, sits in the upper half and the check value in the lower half. The block does not store the protected data and does not move it over any bus.

The controller has four states. `ST_IDLE` is the state after reset and after a report. `ST_ACCEPT` waits for a quadlet with `in_ready` high. `ST_FOLD` folds one nibble per cycle for eight cycles. `ST_REPORT` asserts `done` for one cycle.

The transitions are:
- `start` from any state goes to `ST_ACCEPT`, or to `ST_REPORT` when the count is zero.
- A handshake moves `ST_ACCEPT` to `ST_FOLD`.
- The eighth fold goes back to `ST_ACCEPT` when quadlets remain, otherwise to `ST_REPORT`.
- `ST_REPORT` always returns to `ST_IDLE`.

Top module: `qcrc16_engine`

## Requirements
- R1: After reset `done` and `in_ready` are 0, and `crc_out` and `header_out` are 0.
- R2: A `start` pulse clears the running check to 0 and latches `quad_count` and `hdr_en`. When the count is nonzero, `in_ready` is 1 in the cycle after `start`.
- R3: Each quadlet is folded as eight nibbles, bits 31..28 first and bits 3..0 last. For each nibble, s = (c[15:12] XOR nibble) and the new c is ((c << 4) XOR (s << 12) XOR (s << 5) XOR s), truncated to 16 bits. The check carries across quadlets, and the final `crc_out` equals this function over all the quadlets in order.
- R4: After a quadlet is accepted, `in_ready` stays 0 for exactly 8 cycles before `in_ready` or `done` rises.
- R5: `in_valid` is ignored while `in_ready` is 0. With `in_ready` high and `in_valid` low, the check does not change.
- R6: `done` is 1 for exactly one cycle, in the cycle after the last fold of the last quadlet. `crc_out` and `header_out` then hold until the next `start`.
- R7: A `start` with `quad_count` = 0 gives `done` in the next cycle, with `crc_out` = 0x0000.
- R8: With `hdr_en` latched as 1, `header_out` = {count[15:0], crc_out}. With `hdr_en` latched as 0, `header_out` = {16'h0000, crc_out}.
- R9: A `start` given during `ST_ACCEPT` or `ST_FOLD` abandons the running computation and reinitialises from the new count. The result covers only the quadlets that follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Clear and begin a new computation |
| quad_count | input | CNT_W | Number of quadlets to cover, sampled on `start` |
| hdr_en | input | 1 | Header option, sampled on `start` |
| in_valid | input | 1 | Quadlet offered |
| in_data | input | 32 | Quadlet value, most significant nibble folded first |
| in_ready | output | 1 | Block can take a quadlet |
| done | output | 1 | One-cycle result strobe |
| crc_out | output | 16 | Check value |
| header_out | output | 32 | Header quadlet, or the check value zero-extended |

## Verification
The case hardest to reach from the ports is a restart that lands in the middle of a fold. The engine is then mid-quadlet: the shift register is part-consumed and the quadlet count is partly spent. The stimulus accepts a quadlet of a longer block and waits three cycles into the fold. It then pulses `start` with a different count and checks that the result matches only the quadlets that follow. A second restart is issued while the engine waits in the accept state. Noise on `in_valid` while `in_ready` is low is driven during folds, so that any leak into the shift register shows up in the final value.

// File: rtl/qcrc_pkg.sv
package qcrc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ACCEPT,
        ST_FOLD,
        ST_REPORT
    } qcrc_state_t;

    localparam int unsigned NIB_W = 4;
endpackage

// File: rtl/qcrc_nib_fold.sv
module qcrc_nib_fold #(
    parameter int unsigned CW    = 16,
    parameter int unsigned TAP_M = 5
) (
    input  logic [CW-1:0] crc_in,
    input  logic [3:0]    nib,
    output logic [CW-1:0] crc_nx
);
    logic [3:0]    s;
    logic [CW-1:0] s_top;
    logic [CW-1:0] s_mid;
    logic [CW-1:0] s_low;
    logic [CW-1:0] shifted;

    always_comb begin
        s       = crc_in[CW-1 -: 4] ^ nib;
        s_top   = {s, {(CW-4){1'b0}}};
        s_low   = {{(CW-4){1'b0}}, s};
        s_mid   = s_low << TAP_M;
        shifted = {crc_in[CW-5:0], 4'b0000};
        crc_nx  = shifted ^ s_top ^ s_mid ^ s_low;
    end
endmodule

// File: rtl/qcrc_ctrl.sv
module qcrc_ctrl
    import qcrc_pkg::*;
#(
    parameter int unsigned CNT_W = 16,
    parameter int unsigned NIBS  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] quad_count,
    input  logic             in_valid,
    output logic             in_ready,
    output logic             done,
    output logic             clr,
    output logic             load,
    output logic             fold_en
);
    localparam int unsigned IDX_W = (NIBS > 1) ? $clog2(NIBS) : 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NIBS - 1);
    localparam logic [CNT_W-1:0] ONE_LEFT = CNT_W'(1);

    qcrc_state_t       st_q, st_nx;
    logic [CNT_W-1:0]  left_q;
    logic [IDX_W-1:0]  idx_q;
    logic              last_nib;

    assign last_nib = (idx_q == LAST_IDX);

    always_comb begin
        st_nx = st_q;
        if (start) begin
            st_nx = (quad_count == '0) ? ST_REPORT : ST_ACCEPT;
        end else begin
            unique case (st_q)
                ST_IDLE:   st_nx = ST_IDLE;
                ST_ACCEPT: if (in_valid) st_nx = ST_FOLD;
                ST_FOLD:   if (last_nib) st_nx = (left_q == ONE_LEFT) ? ST_REPORT : ST_ACCEPT;
                ST_REPORT: st_nx = ST_IDLE;
                default:   st_nx = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            left_q <= '0;
            idx_q  <= '0;
        end else if (start) begin
            left_q <= quad_count;
            idx_q  <= '0;
        end else if (st_q == ST_ACCEPT && in_valid) begin
            idx_q  <= '0;
        end else if (st_q == ST_FOLD) begin
            idx_q  <= idx_q + 1'b1;
            if (last_nib) left_q <= left_q - 1'b1;
        end
    end

    always_comb begin
        in_ready = 1'b0;
        done     = 1'b0;
        load     = 1'b0;
        fold_en  = 1'b0;
        clr      = start;
        unique case (st_q)
            ST_IDLE:   ;
            ST_ACCEPT: begin
                in_ready = 1'b1;
                load     = in_valid & ~start;
            end
            ST_FOLD:   fold_en = ~start;
            ST_REPORT: done = 1'b1;
            default:   ;
        endcase
    end
endmodule

// File: rtl/qcrc_datapath.sv
module qcrc_datapath #(
    parameter int unsigned DW    = 32,
    parameter int unsigned CW    = 16,
    parameter int unsigned CNT_W = 16,
    parameter int unsigned LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             load,
    input  logic             fold_en,
    input  logic [CNT_W-1:0] quad_count,
    input  logic             hdr_en,
    input  logic [DW-1:0]    in_data,
    output logic [CW-1:0]    crc_out,
    output logic [DW-1:0]    header_out
);
    logic [DW-1:0]    sh_q;
    logic [CW-1:0]    crc_q;
    logic [CW-1:0]    crc_nx;
    logic [CNT_W-1:0] len_q;
    logic             hdr_q;
    logic [LEN_W-1:0] len_f;

    qcrc_nib_fold #(.CW(CW), .TAP_M(5)) u_fold (
        .crc_in (crc_q),
        .nib    (sh_q[DW-1 -: 4]),
        .crc_nx (crc_nx)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q  <= '0;
            crc_q <= '0;
            len_q <= '0;
            hdr_q <= 1'b0;
        end else if (clr) begin
            crc_q <= '0;
            len_q <= quad_count;
            hdr_q <= hdr_en;
        end else if (load) begin
            sh_q  <= in_data;
        end else if (fold_en) begin
            crc_q <= crc_nx;
            sh_q  <= {sh_q[DW-5:0], 4'b0000};
        end
    end

    generate
        if (CNT_W >= LEN_W) begin : g_len_cut
            assign len_f = len_q[LEN_W-1:0];
        end else begin : g_len_ext
            assign len_f = {{(LEN_W-CNT_W){1'b0}}, len_q};
        end
    endgenerate

    assign crc_out    = crc_q;
    assign header_out = hdr_q ? {len_f, crc_q} : {{(DW-CW){1'b0}}, crc_q};
endmodule

// File: rtl/qcrc16_engine.sv
module qcrc16_engine #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] quad_count,
    input  logic             hdr_en,
    input  logic             in_valid,
    input  logic [31:0]      in_data,
    output logic             in_ready,
    output logic             done,
    output logic [15:0]      crc_out,
    output logic [31:0]      header_out
);
    localparam int unsigned DW   = 32;
    localparam int unsigned CW   = 16;
    localparam int unsigned NIBS = DW / qcrc_pkg::NIB_W;

    logic clr, load, fold_en;

    qcrc_ctrl #(.CNT_W(CNT_W), .NIBS(NIBS)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .quad_count (quad_count),
        .in_valid   (in_valid),
        .in_ready   (in_ready),
        .done       (done),
        .clr        (clr),
        .load       (load),
        .fold_en    (fold_en)
    );

    qcrc_datapath #(.DW(DW), .CW(CW), .CNT_W(CNT_W), .LEN_W(DW - CW)) u_dp (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (clr),
        .load       (load),
        .fold_en    (fold_en),
        .quad_count (quad_count),
        .hdr_en     (hdr_en),
        .in_data    (in_data),
        .crc_out    (crc_out),
        .header_out (header_out)
    );
endmodule

// File: rtl/qcrc16_checker.sv
module qcrc16_checker #(
    parameter int unsigned CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic [CNT_W-1:0] quad_count,
    input logic             in_valid,
    input logic             in_ready,
    input logic             done,
    input logic [15:0]      crc_out
);
    localparam int unsigned FOLDS = 32 / 4;

    logic       trk_q;
    logic [4:0] low_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            trk_q <= 1'b0;
            low_q <= '0;
        end else if (start) begin
            trk_q <= 1'b0;
        end else if (in_valid && in_ready) begin
            trk_q <= 1'b1;
            low_q <= '0;
        end else if (trk_q && !in_ready && !done) begin
            low_q <= low_q + 1'b1;
        end else if (trk_q) begin
            trk_q <= 1'b0;
        end
    end

    assert_fold_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (trk_q && (in_ready || done) && !start) |-> (low_q == 5'(FOLDS)));

    assert_ready_drops_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && !start) |=> !in_ready);

    assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> !done);

    assert_zero_count_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (start && quad_count == '0) |=> (done && crc_out == 16'h0000));

    assert_idle_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ready && !in_valid && !start) |=> $stable(crc_out));

    assert_start_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (start && quad_count != '0) |=> (in_ready && crc_out == 16'h0000));
endmodule

bind qcrc16_engine qcrc16_checker #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .quad_count (quad_count),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .done       (done),
    .crc_out    (crc_out)
);

// File: tb/sim_qcrc16_engine.sv
`timescale 1ns/1ps
module sim_qcrc16_engine;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] quad_count = '0;
    logic        hdr_en = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_data = '0;
    logic        in_ready;
    logic        done;
    logic [15:0] crc_out;
    logic [31:0] header_out;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    always #2 clk = ~clk;

    qcrc16_engine #(.CNT_W(16)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .quad_count(quad_count),
        .hdr_en(hdr_en), .in_valid(in_valid), .in_data(in_data),
        .in_ready(in_ready), .done(done), .crc_out(crc_out), .header_out(header_out)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            fails = fails + 1;
            $display("FAIL watchdog: run hung, actual cycles=%0d expected below 150000", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            fails = fails + 1;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] qgen(input int p, input int q);
        case (p)
            0:       return 32'hFFFF_FFFF;
            1:       return (q * 32'h0123_4567) ^ 32'h89AB_CDEF;
            2:       return 32'h1 << ((q * 5) % 32);
            default: return (q + 1) * 32'h9E37_79B9;
        endcase
    endfunction

    function automatic logic [15:0] ref_crc(input int p, input int n);
        int unsigned acc = 0;
        for (int i = 0; i < n; i++) begin
            int unsigned nx = acc;
            int unsigned d  = qgen(p, i);
            for (int sh = 28; sh >= 0; sh -= 4) begin
                int unsigned s = ((nx >> 12) ^ (d >> sh)) & 32'hF;
                nx = (nx << 4) ^ (s << 12) ^ (s << 5) ^ s;
            end
            acc = nx & 32'hFFFF;
        end
        return acc[15:0];
    endfunction

    task automatic pulse_start(input int n, input logic hm);
        @(negedge clk);
        start = 1'b1; quad_count = 16'(n); hdr_en = hm;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic feed(input int n, input int p, input bit noisy);
        for (int q = 0; q < n; q++) begin
            int lows = 0;
            while (!in_ready) @(negedge clk);
            in_valid = 1'b1; in_data = qgen(p, q);
            @(negedge clk);
            in_valid = 1'b0;
            while (!in_ready && !done) begin
                lows++;
                if (noisy && lows <= 3) begin
                    in_valid = 1'b1; in_data = ~qgen(p, q) ^ 32'(lows);
                end else begin
                    in_valid = 1'b0;
                end
                @(negedge clk);
            end
            in_valid = 1'b0;
            chk("R4 ready-low cycles per quadlet", 32'(lows), 32'd8);
        end
    endtask

    task automatic finish_check(input int n, input int p, input logic hm, input string tag);
        logic [15:0] e;
        e = ref_crc(p, n);
        chk({"R6 done on completion ", tag}, {31'b0, done}, 32'd1);
        chk({"R3 crc value ", tag}, {16'h0, crc_out}, {16'h0, e});
        chk({"R8 header form ", tag}, header_out, hm ? {16'(n), e} : {16'h0, e});
        @(negedge clk);
        chk({"R6 done single cycle ", tag}, {31'b0, done}, 32'd0);
        @(negedge clk);
        chk({"R6 result held ", tag}, {16'h0, crc_out}, {16'h0, e});
    endtask

    task automatic run(input int n, input int p, input logic hm, input bit noisy);
        pulse_start(n, hm);
        if (n == 0) begin
            chk("R7 zero count done", {31'b0, done}, 32'd1);
            chk("R7 zero count crc", {16'h0, crc_out}, 32'd0);
            finish_check(0, p, hm, "zero");
        end else begin
            chk("R2 ready after start", {31'b0, in_ready}, 32'd1);
            chk("R2 crc cleared", {16'h0, crc_out}, 32'd0);
            feed(n, p, noisy);
            finish_check(n, p, hm, noisy ? "R5 noisy" : "sweep");
        end
    endtask

    initial begin
        #1;
        chk("R1 reset done", {31'b0, done}, 32'd0);
        chk("R1 reset ready", {31'b0, in_ready}, 32'd0);
        chk("R1 reset crc", {16'h0, crc_out}, 32'd0);
        chk("R1 reset header", header_out, 32'd0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 idle after reset", {31'b0, in_ready}, 32'd0);

        for (int p = 0; p < 4; p++)
            for (int n = 0; n <= 6; n++)
                for (int h = 0; h < 2; h++)
                    run(n, p, h[0], (n % 2) == 1 && p == 1);

        run(1, 3, 1'b0, 1'b1);

        // R9: restart three cycles into a fold
        pulse_start(3, 1'b1);
        while (!in_ready) @(negedge clk);
        in_valid = 1'b1; in_data = 32'hDEAD_BEEF;
        @(negedge clk);
        in_valid = 1'b0;
        repeat (3) @(negedge clk);
        run(2, 2, 1'b1, 1'b0);

        // R9: restart while waiting for a quadlet
        pulse_start(5, 1'b0);
        while (!in_ready) @(negedge clk);
        in_valid = 1'b1; in_data = 32'h1234_5678;
        @(negedge clk);
        in_valid = 1'b0;
        while (!in_ready) @(negedge clk);
        run(3, 0, 1'b1, 1'b0);

        // R5: idle valid in ST_IDLE leaves result alone
        in_valid = 1'b1; in_data = 32'hFFFF_0000;
        repeat (4) @(negedge clk);
        in_valid = 1'b0;
        chk("R5 idle valid ignored", {16'h0, crc_out}, {16'h0, ref_crc(0, 3)});

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule